// File: doc/BRIEF.md
# Multiprocessor Debug-Halt Coordinator

This block decides when each processor in a small cluster stops for debug and when it runs again. A processor halts when its own debug request arrives, carrying a trap type and an error-mode flag, or when software raises that processor's break request. The block can also carry a halt from one processor to the others. Each processor has an enable bit that allows others to force it into debug. Each processor also has a mask bit that stops its own halt from spreading. A halted processor runs again only after an explicit resume command for it.

For each processor, the block records why it halted in a read-only cause register. It also keeps a 30-bit time tag that counts clocks while any processor is running and freezes while all are halted. An 8-bit space identifier is held for debug-initiated accesses and driven out on `asi_id`.

Software uses a word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the current state:
- address 0: propagation control
- address 1: time tag
- address 2: space identifier
- address 4+i: cause register of processor i

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset, all processors run, and the control, time tag, space identifier and all cause registers read zero.
- R2: A running processor with `dbg_req` high halts at the next edge. Its cause register then reads the trap type in bits [11:4], the error-mode flag in bit 12, and zero in bits [3:0].
- R3: A running processor with `sw_brk` high and `dbg_req` low halts at the next edge, with trap type 0x0B and the error-mode flag cleared. When both are high, the `dbg_req` trap type and flag are recorded.
- R4: Propagation works as follows:
  - An own entry is a halt caused by `dbg_req` or `sw_brk`.
  - When processor j makes an own entry at edge k, each other running processor i is halted at edge k+1 if control bit i is set.
  - A processor halted this way records trap type 0x0B with the error-mode flag cleared.
- R5: A processor whose mask bit (control bit 16+i) is set halts normally, but its own entry forces no other processor.
- R6: A processor whose enable bit (control bit i) is clear is never halted by another processor's entry.
- R7: A halt caused by propagation is not itself a source of propagation.
- R8: A cause register is written only when its processor goes from running to halted. It keeps its value while that processor stays halted, whatever requests arrive.
- R9: A halted processor leaves debug only at the edge where its own `resume` bit is high. A resume bit for a running processor has no effect.
- R10: The time tag counts up by one every clock while at least one processor is running, and holds its value while all are halted. It is 30 bits wide, wraps to zero, and bits [31:30] read zero.
- R11: A write to address 1 loads the time tag from bits [29:0] of the write data, and the write takes precedence over counting.
- R12: The space identifier at address 2 is writable in bits [7:0] and drives `asi_id`. Its upper bits read zero.
- R13: Writes to the cause registers have no effect. Control bits that belong to no implemented processor read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_req | input | NCPU | Per-processor debug-entry request from its own trap |
| dbg_tt | input | 8*NCPU | Trap type per processor, processor i in bits [8i+7:8i] |
| dbg_em | input | NCPU | Per-processor error-mode flag accompanying the trap |
| sw_brk | input | NCPU | Per-processor software break request |
| resume | input | NCPU | Per-processor resume command |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address of register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| halted | output | NCPU | Per-processor debug-halt state |
| asi_id | output | 8 | Space identifier for debug-initiated accesses |

## Verification
The bench builds the block with four processors, so processors can act as a masked source, as enabled targets, or as excluded ones at the same time. With four processors, the bench can resume a source processor in the same cycle its targets are forced in. A cascade would then show up as that source being halted again. Presetting the time tag near 2^30 brings the wrap point within a few cycles. A randomized stretch with per-cycle comparison covers collisions between requests, resumes and register writes.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  localparam int TT_W      = 8;
  localparam int DATA_W    = 32;
  localparam int MASK_LSB  = 16;
  localparam int TT_LSB    = 4;
  localparam int EM_BIT    = 12;
  localparam int ASI_W     = 8;
  localparam int ADR_CTRL  = 0;
  localparam int ADR_TAG   = 1;
  localparam int ADR_ASI   = 2;
  localparam int ADR_CAUSE = 4;
  localparam logic [TT_W-1:0] BRK_TT = 8'h0B;

  typedef struct packed {
    logic            em;
    logic [TT_W-1:0] tt;
  } cause_t;
endpackage

// File: rtl/dbgc_cpu_slice.sv
module dbgc_cpu_slice
  import dbgc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [TT_W-1:0] tt,
  input  logic            em,
  input  logic            brk,
  input  logic            resume,
  input  logic            force_in,
  output logic            halted,
  output logic            own_entry,
  output cause_t          cause
);
  logic   halted_q, halted_d;
  cause_t cause_q, cause_d;
  logic   cause_en;

  always_comb begin
    halted_d  = halted_q;
    cause_d   = cause_q;
    cause_en  = 1'b0;
    own_entry = 1'b0;
    if (halted_q) begin
      if (resume) halted_d = 1'b0;
    end else if (req) begin
      halted_d  = 1'b1;
      own_entry = 1'b1;
      cause_en  = 1'b1;
      cause_d   = '{em: em, tt: tt};
    end else if (brk) begin
      halted_d  = 1'b1;
      own_entry = 1'b1;
      cause_en  = 1'b1;
      cause_d   = '{em: 1'b0, tt: BRK_TT};
    end else if (force_in) begin
      halted_d  = 1'b1;
      cause_en  = 1'b1;
      cause_d   = '{em: 1'b0, tt: BRK_TT};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      cause_q  <= '0;
    end else begin
      halted_q <= halted_d;
      if (cause_en) cause_q <= cause_d;
    end
  end

  assign halted = halted_q;
  assign cause  = cause_q;
endmodule

// File: rtl/dbgc_tag_cnt.sv
module dbgc_tag_cnt #(
  parameter int TAG_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr,
  input  logic [TAG_W-1:0] wdata,
  output logic [TAG_W-1:0] tag
);
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             tag_en;

  always_comb begin
    tag_en = wr | run;
    if (wr) tag_d = wdata;
    else    tag_d = tag_q + TAG_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (tag_en) tag_q <= tag_d;
  end

  assign tag = tag_q;
endmodule

// File: rtl/dbgc_regs.sv
module dbgc_regs
  import dbgc_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int TAG_W  = 30,
  parameter int ADDR_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [TAG_W-1:0]        tag,
  input  cause_t                  cause [NCPU],
  output logic [NCPU-1:0]         prop_en,
  output logic [NCPU-1:0]         prop_mask,
  output logic [ASI_W-1:0]        asi,
  output logic                    tag_wr,
  output logic [DATA_W-1:0]       rdata
);
  logic [NCPU-1:0]  en_q, en_d, mask_q, mask_d;
  logic [ASI_W-1:0] asi_q, asi_d;
  logic             ctrl_wr, asi_wr;

  always_comb begin
    ctrl_wr = we && (addr == ADDR_W'(ADR_CTRL));
    asi_wr  = we && (addr == ADDR_W'(ADR_ASI));
    tag_wr  = we && (addr == ADDR_W'(ADR_TAG));
    en_d    = wdata[NCPU-1:0];
    mask_d  = wdata[MASK_LSB +: NCPU];
    asi_d   = wdata[ASI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      asi_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= en_d;
        mask_q <= mask_d;
      end
      if (asi_wr) asi_q <= asi_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADR_CTRL)) begin
      rdata[NCPU-1:0]          = en_q;
      rdata[MASK_LSB +: NCPU]  = mask_q;
    end else if (addr == ADDR_W'(ADR_TAG)) begin
      rdata[TAG_W-1:0] = tag;
    end else if (addr == ADDR_W'(ADR_ASI)) begin
      rdata[ASI_W-1:0] = asi_q;
    end else begin
      for (int i = 0; i < NCPU; i++) begin
        if (addr == ADDR_W'(ADR_CAUSE + i)) begin
          rdata[TT_LSB +: TT_W] = cause[i].tt;
          rdata[EM_BIT]         = cause[i].em;
        end
      end
    end
  end

  assign prop_en   = en_q;
  assign prop_mask = mask_q;
  assign asi       = asi_q;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbgc_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int TAG_W  = 30,
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCPU-1:0]        dbg_req,
  input  logic [NCPU*TT_W-1:0]   dbg_tt,
  input  logic [NCPU-1:0]        dbg_em,
  input  logic [NCPU-1:0]        sw_brk,
  input  logic [NCPU-1:0]        resume,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  output logic [NCPU-1:0]        halted,
  output logic [ASI_W-1:0]       asi_id
);
  logic [NCPU-1:0]  own_entry, force_in, prop_en, prop_mask;
  logic [NCPU-1:0]  src_q, src_d;
  logic [TAG_W-1:0] tag;
  logic             tag_wr, run;
  cause_t           cause [NCPU];

  always_comb src_d = own_entry & ~prop_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    logic [NCPU-1:0] others;
    always_comb begin
      others    = src_q;
      others[g] = 1'b0;
      force_in[g] = prop_en[g] & (|others);
    end

    dbgc_cpu_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (dbg_req[g]),
      .tt        (dbg_tt[g*TT_W +: TT_W]),
      .em        (dbg_em[g]),
      .brk       (sw_brk[g]),
      .resume    (resume[g]),
      .force_in  (force_in[g]),
      .halted    (halted[g]),
      .own_entry (own_entry[g]),
      .cause     (cause[g])
    );
  end

  assign run = ~&halted;

  dbgc_tag_cnt #(.TAG_W(TAG_W)) u_tag (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .wr    (tag_wr),
    .wdata (reg_wdata[TAG_W-1:0]),
    .tag   (tag)
  );

  dbgc_regs #(.NCPU(NCPU), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .tag       (tag),
    .cause     (cause),
    .prop_en   (prop_en),
    .prop_mask (prop_mask),
    .asi       (asi_id),
    .tag_wr    (tag_wr),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk
  import dbgc_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int TAG_W = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCPU-1:0]  halted,
  input logic [NCPU-1:0]  req,
  input logic [NCPU-1:0]  brk,
  input logic [NCPU-1:0]  resume,
  input logic [NCPU-1:0]  prop_en,
  input logic [TAG_W-1:0] tag,
  input logic             tag_wr,
  input cause_t           cause [NCPU]
);
  for (genvar g = 0; g < NCPU; g++) begin : g_p
    p_own_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !halted[g] && req[g] |=> halted[g]);
    p_no_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !halted[g] && !req[g] && !brk[g] && !prop_en[g] |=> !halted[g]);
    p_cause_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted[g] && !resume[g] |=> $stable(cause[g]));
    p_stay_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halted[g] && !resume[g] |=> halted[g]);
    p_resume_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halted[g] && resume[g] |=> !halted[g]);
  end

  p_tag_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (&halted) && !tag_wr |=> $stable(tag));
  p_tag_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(&halted) && !tag_wr |=> tag == TAG_W'($past(tag) + TAG_W'(1)));
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.NCPU(NCPU), .TAG_W(TAG_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .halted  (halted),
  .req     (dbg_req),
  .brk     (sw_brk),
  .resume  (resume),
  .prop_en (prop_en),
  .tag     (tag),
  .tag_wr  (tag_wr),
  .cause   (cause)
);

// File: tb/sim_dbg_halt_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_halt_ctrl;
  localparam int N = 4;
  localparam int AW = 5;
  localparam int TMASK = 32'h3FFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  dbg_req = '0, dbg_em = '0, sw_brk = '0, resume = '0;
  logic [N*8-1:0] dbg_tt = '0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  halted;
  logic [7:0]    asi_id;

  always #10 clk = ~clk;

  dbg_halt_ctrl #(.NCPU(N), .TAG_W(30), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .dbg_tt(dbg_tt), .dbg_em(dbg_em),
    .sw_brk(sw_brk), .resume(resume), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halted(halted), .asi_id(asi_id));

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string tagname = "R1";

  bit [N-1:0] mh, msrc;
  bit [7:0]   mtt [N];
  bit         mem [N];
  bit [31:0]  mctrl;
  int unsigned mtag;
  bit [7:0]   masi;

  function automatic bit [31:0] mread(input int a);
    if (a == 0) return mctrl;
    if (a == 1) return mtag & TMASK;
    if (a == 2) return {24'd0, masi};
    if (a >= 4 && a < 4 + N) return ({19'd0, mem[a-4], 12'd0}) | (32'(mtt[a-4]) << 4);
    return 32'd0;
  endfunction

  task automatic check(input string what, input bit [31:0] act, input bit [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tagname, what, act, exp);
    end
  endtask

  task automatic step();
    bit [N-1:0] nh, ns;
    bit [7:0]   ntt [N];
    bit         nem [N];
    bit [31:0]  nctrl;
    int unsigned ntag;
    bit [7:0]   nasi;
    nh = mh; ns = '0; nctrl = mctrl; nasi = masi; ntag = mtag;
    for (int i = 0; i < N; i++) begin
      bit hit;
      ntt[i] = mtt[i]; nem[i] = mem[i];
      hit = 0;
      for (int j = 0; j < N; j++) if (j != i && msrc[j]) hit = 1;
      if (mh[i]) begin
        if (resume[i]) nh[i] = 0;
      end else if (dbg_req[i]) begin
        nh[i] = 1; ntt[i] = dbg_tt[i*8 +: 8]; nem[i] = dbg_em[i]; ns[i] = !mctrl[16+i];
      end else if (sw_brk[i]) begin
        nh[i] = 1; ntt[i] = 8'h0B; nem[i] = 0; ns[i] = !mctrl[16+i];
      end else if (mctrl[i] && hit) begin
        nh[i] = 1; ntt[i] = 8'h0B; nem[i] = 0;
      end
    end
    if (reg_we && reg_addr == 1) ntag = reg_wdata & TMASK;
    else if (mh != {N{1'b1}}) ntag = (mtag + 1) & TMASK;
    if (reg_we && reg_addr == 0) nctrl = reg_wdata & 32'h000F_000F;
    if (reg_we && reg_addr == 2) nasi = reg_wdata[7:0];
    @(posedge clk);
    #1;
    mh = nh; msrc = ns; mctrl = nctrl; masi = nasi; mtag = ntag;
    for (int i = 0; i < N; i++) begin mtt[i] = ntt[i]; mem[i] = nem[i]; end
    check("halted", 32'(halted), 32'(mh));
    check("asi_id", 32'(asi_id), 32'(masi));
    check($sformatf("rdata@%0d", reg_addr), reg_rdata, mread(int'(reg_addr)));
  endtask

  task automatic idle();
    dbg_req = '0; sw_brk = '0; resume = '0; reg_we = 0;
  endtask

  task automatic wr(input int a, input bit [31:0] d);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = d; step(); reg_we = 0;
  endtask

  task automatic rd(input int a, input bit [31:0] exp, input string what);
    reg_addr = AW'(a); #1;
    check(what, reg_rdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    mh = '0; msrc = '0; mctrl = '0; mtag = 0; masi = '0;
    for (int i = 0; i < N; i++) begin mtt[i] = '0; mem[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    tagname = "R1";
    check("halted after reset", 32'(halted), 0);
    for (int a = 0; a < 8; a++) rd(a, (a == 1) ? mtag : 32'd0, $sformatf("reg %0d after reset", a));
    idle(); step();

    // R2 own trap, R6 no forcing with enables clear
    tagname = "R2";
    dbg_tt[7:0] = 8'h55; dbg_em[0] = 1; dbg_req[0] = 1; reg_addr = 4; step();
    idle(); dbg_em = '0; step();
    check("R2 cause0", reg_rdata, 32'h0000_1550);
    tagname = "R6";
    check("R6 others running", 32'(halted), 32'h1);

    // R8 cause held while halted
    tagname = "R8";
    dbg_tt[7:0] = 8'h22; dbg_req[0] = 1; step(); idle(); step();
    check("R8 cause0 held", reg_rdata, 32'h0000_1550);

    // R9 resume of running cpu ignored, then resume cpu0
    tagname = "R9";
    resume = 4'b0010; step(); idle();
    check("R9 cpu1 still running", 32'(halted), 32'h1);
    resume = 4'b0001; step(); idle();
    check("R9 cpu0 resumed", 32'(halted), 32'h0);

    // R3 break, R4 propagation
    tagname = "R4";
    wr(0, 32'h0000_000E);
    sw_brk[0] = 1; step(); idle();
    check("R3 break halts only source first", 32'(halted), 32'h1);
    step();
    check("R4 targets forced", 32'(halted), 32'hF);
    rd(4, 32'h0000_00B0, "R3 break cause");
    rd(6, 32'h0000_00B0, "R4 forced cause");

    // R10 all halted: tag frozen
    tagname = "R10";
    repeat (5) step();
    resume = 4'hF; step(); idle(); step();

    // R5 masked source
    tagname = "R5";
    wr(0, 32'h0004_000F);
    dbg_tt[23:16] = 8'h31; dbg_req[2] = 1; step(); idle(); step(); step();
    check("R5 masked source alone", 32'(halted), 32'h4);
    resume = 4'h4; step(); idle();

    // R7 forced entries do not cascade
    tagname = "R7";
    wr(0, 32'h0000_0007);
    dbg_req[2] = 1; step(); idle();
    resume = 4'h4; step(); idle();
    check("R7 cpu0/1 forced, cpu2 resumed", 32'(halted), 32'h3);
    step(); step();
    check("R7 cpu2 not re-forced", 32'(halted), 32'h3);
    resume = 4'hF; step(); idle();

    // R3 req wins over brk
    tagname = "R3";
    wr(0, 32'h0);
    dbg_tt[31:24] = 8'h77; dbg_req[3] = 1; sw_brk[3] = 1; step(); idle();
    rd(7, 32'h0000_0770, "R3 req beats brk");
    resume = 4'h8; step(); idle();

    // R11 tag preset and R10 wrap
    tagname = "R11";
    wr(1, 32'hFFFF_FFFE);
    reg_addr = 1;
    check("R11 preset", reg_rdata, 32'h3FFF_FFFE);
    tagname = "R10";
    step(); step();
    check("R10 wrap", reg_rdata, 32'h0000_0000);

    // R12 space identifier
    tagname = "R12";
    wr(2, 32'hFFFF_FF5A);
    check("R12 asi_id", 32'(asi_id), 32'h5A);
    rd(2, 32'h0000_005A, "R12 readback");

    // R13 cause writes ignored, unimplemented ctrl bits zero
    tagname = "R13";
    wr(5, 32'hFFFF_FFFF);
    rd(5, 32'h0000_00B0, "R13 cause1 unchanged");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h000F_000F, "R13 ctrl implemented bits");

    // randomized stretch, all requirements vs model
    tagname = "R4";
    for (int c = 0; c < 600; c++) begin
      dbg_req = N'($urandom_range(0, 15) & $urandom_range(0, 15) & $urandom_range(0, 15));
      sw_brk  = N'($urandom_range(0, 15) & $urandom_range(0, 15) & $urandom_range(0, 15));
      resume  = N'($urandom_range(0, 15) & $urandom_range(0, 15));
      dbg_tt  = $urandom;
      dbg_em  = N'($urandom_range(0, 15));
      reg_we  = ($urandom_range(0, 15) == 0);
      reg_addr = AW'($urandom_range(0, 8));
      reg_wdata = $urandom;
      step();
    end
    idle(); step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule